// File: doc/BRIEF.md
# Debug Hart Selection Controller

This block is the run-control front of an external debug module for a small system with several harts. A debugger reaches it through a simple register port with a write strobe, a 2-bit address, write data and combinational read data. Through that port the debugger picks one hart by index. It can also set an array-select enable, which adds every hart whose bit is set in a mask register. The block then reports aggregate status over that selected set and drives halt and resume requests to the harts.

Halt requests are levels and stay on until the debugger writes them off. A resume is a single-cycle pulse. It goes only to selected harts that are halted at the moment of the write, and the block tracks whether each resumed hart has since been seen running. The block also checks abstract commands before they are issued. Register-transfer fields are examined only when the command asks for a transfer, so unused size and register-number bits can never raise an error.

The block is used with one debugger-facing register interface. The per-hart halted levels come in from the cores, and the request vectors go back to them.

Top module: `dbg_hartsel_ctrl`

## Requirements
- R1: The selected set is the hart whose number equals the index field (control bits [7:4]) plus, when the array-select enable (control bit 1) is set, every hart whose mask bit is 1. A halt request written through the control register reaches exactly that set.
- R2: Status bit 4 (any nonexistent) is 1 exactly when the index is at or above NUM_HARTS. Status bit 5 (all nonexistent) is 1 exactly when the index is at or above NUM_HARTS and no mask hart is selected, so the array-select enable never forces it low by itself.
- R3: A halt request (control bit 31) is a level. A control write updates it only for the harts selected by that write, and every other hart keeps its value.
- R4: A control write with bit 30 set and bit 31 clear puts a one-cycle pulse on resume_req for each selected hart that is halted, and clears that hart's acknowledge flag. The flag sets once the hart later reports running. Status bit 6 is the OR and bit 7 is the AND of the flags over the selected harts.
- R5: A control write with both bit 30 and bit 31 set produces no resume pulse and leaves the acknowledge flags unchanged.
- R6: Status bits 0 and 1 are any-halted and all-halted, and bits 2 and 3 are any-running and all-running. Each is computed over the selected existing harts, and each "all" bit reads 0 when no existing hart is selected.
- R7: The mask register sits at address 1. Bits for harts at or above NUM_HARTS read as zero and cannot be set.
- R8: A control write with bit 0 (active) clear returns every register and request output to its reset value. While the block is inactive, mask and command writes are ignored.
- R9: A command write (address 2) carries type [31:24], size [23:20], transfer [19], write [18] and register number [17:0]. When transfer is clear, size and register number are ignored, the error code is 0, and cmd_start pulses.
- R10: With transfer set, a size other than 2 or a register number outside 0x1000 to 0x101F gives error code 2 and no start. A type other than 0 always gives error code 2. The error code reads at address 2, bits [2:0]; status is read at address 3 and control at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 control, 1 mask, 2 command, 3 status) |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for addr |
| hart_halted | input | NUM_HARTS | Halted level from each hart |
| halt_req | output | NUM_HARTS | Halt request level per hart |
| resume_req | output | NUM_HARTS | Resume request pulse per hart |
| cmd_start | output | 1 | One-cycle pulse for an accepted command |
| cmd_xfer | output | 1 | Accepted command performs a register transfer |
| cmd_write | output | 1 | Transfer direction, 0 when no transfer |
| cmd_regno | output | 16 | Register number, 0 when no transfer |

## Verification
A single control write can carry a halt request and a resume request at the same time. When both bits are set, the halt must take effect on the selected harts while the resume is dropped. The bench provokes this with all harts halted and a write that sets bits 31 and 30 together. At the following falling edge it judges that resume_req is all zero and that the halt bit for the indexed hart has risen. It then repeats the write with only the resume bit and confirms that the pulse appears and that the halt level is cleared.

// File: rtl/hsel_pkg.sv
package hsel_pkg;
    localparam int IDX_W = 4;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_MASK = 2'd1;
    localparam logic [1:0] ADDR_CMD  = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    localparam int CTRL_ACTIVE = 0;
    localparam int CTRL_ARR    = 1;
    localparam int CTRL_IDX_LO = 4;
    localparam int CTRL_RESUME = 30;
    localparam int CTRL_HALT   = 31;

    localparam int ST_ANY_HALT  = 0;
    localparam int ST_ALL_HALT  = 1;
    localparam int ST_ANY_RUN   = 2;
    localparam int ST_ALL_RUN   = 3;
    localparam int ST_ANY_NONEX = 4;
    localparam int ST_ALL_NONEX = 5;
    localparam int ST_ANY_ACK   = 6;
    localparam int ST_ALL_ACK   = 7;

    localparam int CMD_XFER_BIT = 19;

    localparam logic [2:0] ERR_NONE  = 3'd0;
    localparam logic [2:0] ERR_UNSUP = 3'd2;
endpackage

// File: rtl/hsel_select.sv
module hsel_select
    import hsel_pkg::*;
#(
    parameter int NUM_HARTS = 4
) (
    input  logic [IDX_W-1:0]     idx,
    input  logic                 arr_en,
    input  logic [NUM_HARTS-1:0] mask,
    input  logic [NUM_HARTS-1:0] halted,
    input  logic [NUM_HARTS-1:0] ack,
    output logic [NUM_HARTS-1:0] sel,
    output logic [7:0]           status
);
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NUM_HARTS);

    for (genvar g = 0; g < NUM_HARTS; g++) begin : g_sel
        assign sel[g] = (idx == IDX_W'(g)) | (arr_en & mask[g]);
    end

    logic                 idx_nonex;
    logic                 any_sel;
    logic [NUM_HARTS-1:0] hlt_v;
    logic [NUM_HARTS-1:0] run_v;
    logic [NUM_HARTS-1:0] ack_v;

    always_comb begin
        idx_nonex = (idx >= LIMIT);
        any_sel   = |sel;
        hlt_v     = sel & halted;
        run_v     = sel & ~halted;
        ack_v     = sel & ack;
        status                = '0;
        status[ST_ANY_HALT]   = |hlt_v;
        status[ST_ALL_HALT]   = any_sel && (hlt_v == sel);
        status[ST_ANY_RUN]    = |run_v;
        status[ST_ALL_RUN]    = any_sel && (run_v == sel);
        status[ST_ANY_NONEX]  = idx_nonex;
        status[ST_ALL_NONEX]  = idx_nonex && !any_sel;
        status[ST_ANY_ACK]    = |ack_v;
        status[ST_ALL_ACK]    = any_sel && (ack_v == sel);
    end
endmodule

// File: rtl/hsel_cmd_check.sv
module hsel_cmd_check
    import hsel_pkg::*;
#(
    parameter logic [17:0] REG_BASE  = 18'h01000,
    parameter int          REG_COUNT = 32,
    parameter logic [3:0]  SIZE_OK   = 4'd2
) (
    input  logic [31:0] cmd,
    output logic [2:0]  err,
    output logic        xfer,
    output logic        wr,
    output logic [15:0] regno
);
    localparam logic [17:0] REG_END = REG_BASE + 18'(REG_COUNT);

    logic [7:0]  c_type;
    logic [3:0]  c_size;
    logic [17:0] c_reg;
    logic        bad_fields;

    always_comb begin
        c_type = cmd[31:24];
        c_size = cmd[23:20];
        xfer   = cmd[CMD_XFER_BIT];
        c_reg  = cmd[17:0];
        bad_fields = (c_size != SIZE_OK) || (c_reg < REG_BASE) || (c_reg >= REG_END);
        if (c_type != 8'd0)          err = ERR_UNSUP;
        else if (xfer && bad_fields) err = ERR_UNSUP;
        else                         err = ERR_NONE;
        wr    = xfer & cmd[18];
        regno = xfer ? c_reg[15:0] : 16'd0;
    end
endmodule

// File: rtl/dbg_hartsel_ctrl.sv
module dbg_hartsel_ctrl
    import hsel_pkg::*;
#(
    parameter int NUM_HARTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           addr,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    input  logic [NUM_HARTS-1:0] hart_halted,
    output logic [NUM_HARTS-1:0] halt_req,
    output logic [NUM_HARTS-1:0] resume_req,
    output logic                 cmd_start,
    output logic                 cmd_xfer,
    output logic                 cmd_write,
    output logic [15:0]          cmd_regno
);
    typedef struct packed {
        logic                 active;
        logic                 arr_en;
        logic [IDX_W-1:0]     idx;
        logic [NUM_HARTS-1:0] mask;
        logic [NUM_HARTS-1:0] halt;
        logic [NUM_HARTS-1:0] resume;
        logic [NUM_HARTS-1:0] pend;
        logic [NUM_HARTS-1:0] ack;
        logic [2:0]           cmd_err;
        logic                 cmd_start;
        logic                 cmd_xfer;
        logic                 cmd_write;
        logic [15:0]          cmd_regno;
    } state_t;

    localparam state_t STATE_RST = '0;

    state_t s_d, s_q;

    logic [NUM_HARTS-1:0] sel_q;
    logic [7:0]           status;
    logic [2:0]           chk_err;
    logic                 chk_xfer;
    logic                 chk_wr;
    logic [15:0]          chk_regno;

    hsel_select #(.NUM_HARTS(NUM_HARTS)) u_sel (
        .idx    (s_q.idx),
        .arr_en (s_q.arr_en),
        .mask   (s_q.mask),
        .halted (hart_halted),
        .ack    (s_q.ack),
        .sel    (sel_q),
        .status (status)
    );

    hsel_cmd_check u_cmd (
        .cmd   (wdata),
        .err   (chk_err),
        .xfer  (chk_xfer),
        .wr    (chk_wr),
        .regno (chk_regno)
    );

    logic                 ctrl_wr;
    logic [IDX_W-1:0]     w_idx;
    logic [NUM_HARTS-1:0] w_sel;
    logic                 w_resume_ok;

    always_comb begin
        s_d           = s_q;
        s_d.resume    = '0;
        s_d.cmd_start = 1'b0;
        ctrl_wr       = wr_en && (addr == ADDR_CTRL);
        w_idx         = wdata[CTRL_IDX_LO +: IDX_W];
        w_resume_ok   = wdata[CTRL_RESUME] && !wdata[CTRL_HALT];

        for (int i = 0; i < NUM_HARTS; i++) begin
            w_sel[i] = (w_idx == IDX_W'(i)) | (wdata[CTRL_ARR] & s_q.mask[i]);
            if (s_q.pend[i] && !hart_halted[i]) begin
                s_d.ack[i]  = 1'b1;
                s_d.pend[i] = 1'b0;
            end
        end

        if (ctrl_wr) begin
            if (!wdata[CTRL_ACTIVE]) begin
                s_d = STATE_RST;
            end else begin
                s_d.active = 1'b1;
                s_d.arr_en = wdata[CTRL_ARR];
                s_d.idx    = w_idx;
                for (int i = 0; i < NUM_HARTS; i++) begin
                    if (w_sel[i]) begin
                        s_d.halt[i] = wdata[CTRL_HALT];
                        if (w_resume_ok && hart_halted[i]) begin
                            s_d.resume[i] = 1'b1;
                            s_d.ack[i]    = 1'b0;
                            s_d.pend[i]   = 1'b1;
                        end
                    end
                end
            end
        end else if (wr_en && s_q.active) begin
            if (addr == ADDR_MASK) begin
                s_d.mask = wdata[NUM_HARTS-1:0];
            end else if (addr == ADDR_CMD) begin
                s_d.cmd_err   = chk_err;
                s_d.cmd_start = (chk_err == ERR_NONE);
                s_d.cmd_xfer  = chk_xfer;
                s_d.cmd_write = chk_wr;
                s_d.cmd_regno = chk_regno;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= STATE_RST;
        else        s_q <= s_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_CTRL: begin
                rdata[CTRL_ACTIVE]            = s_q.active;
                rdata[CTRL_ARR]               = s_q.arr_en;
                rdata[CTRL_IDX_LO +: IDX_W]   = s_q.idx;
            end
            ADDR_MASK: rdata[NUM_HARTS-1:0] = s_q.mask;
            ADDR_CMD:  rdata[2:0]           = s_q.cmd_err;
            default:   rdata[7:0]           = status;
        endcase
    end

    assign halt_req   = s_q.halt;
    assign resume_req = s_q.resume;
    assign cmd_start  = s_q.cmd_start;
    assign cmd_xfer   = s_q.cmd_xfer;
    assign cmd_write  = s_q.cmd_write;
    assign cmd_regno  = s_q.cmd_regno;

    // R5
    conflict_noresume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_CTRL && wdata[CTRL_ACTIVE] && wdata[CTRL_HALT] && wdata[CTRL_RESUME])
        |=> (resume_req == '0));

    // R4
    resume_halted_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|resume_req) |-> ((resume_req & ~$past(hart_halted)) == '0));

    // R8
    inactive_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_CTRL && !wdata[CTRL_ACTIVE])
        |=> (halt_req == '0 && s_q.mask == '0 && !cmd_start));

    // R9
    noxfer_noerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_CMD && s_q.active && wdata[31:24] == 8'd0 && !wdata[CMD_XFER_BIT])
        |=> (s_q.cmd_err == ERR_NONE && cmd_start && !cmd_xfer));

    // R2
    nonex_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_ALL_NONEX] |-> status[ST_ANY_NONEX]);
endmodule

// File: tb/sim_dbg_hartsel_ctrl.sv
module sim_dbg_hartsel_ctrl;
    localparam int N = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [N-1:0]  hart_halted = 4'b0011;
    logic [N-1:0]  halt_req;
    logic [N-1:0]  resume_req;
    logic          cmd_start;
    logic          cmd_xfer;
    logic          cmd_write;
    logic [15:0]   cmd_regno;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dbg_hartsel_ctrl #(.NUM_HARTS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .hart_halted(hart_halted), .halt_req(halt_req),
        .resume_req(resume_req), .cmd_start(cmd_start), .cmd_xfer(cmd_xfer),
        .cmd_write(cmd_write), .cmd_regno(cmd_regno)
    );

    // {addr, wdata, halted, expected status, expected halt_req}
    localparam logic [49:0] VEC [8] = '{
        {2'd0, 32'h0000_0001, 4'b0011, 8'h03, 4'b0000}, // R6 single hart 0
        {2'd1, 32'h0000_000C, 4'b0011, 8'h03, 4'b0000}, // R1 mask without enable
        {2'd0, 32'h0000_0003, 4'b0011, 8'h05, 4'b0000}, // R1 R6 union 0,2,3
        {2'd0, 32'h8000_0053, 4'b0011, 8'h1C, 4'b1100}, // R2 R1 nonexistent index + mask
        {2'd0, 32'h0000_0051, 4'b0011, 8'h30, 4'b1100}, // R2 R3 only nonexistent
        {2'd0, 32'h8000_0021, 4'b0011, 8'h0C, 4'b1100}, // R3 halt hart 2 again
        {2'd0, 32'h0000_0031, 4'b0011, 8'h0C, 4'b0100}, // R3 clear hart 3 only
        {2'd0, 32'h0000_0011, 4'b1111, 8'h03, 4'b0100}  // R6 hart 1 halted
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        addr = a;
        #0.5;
        v = rdata;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R8 reset values, R6 status over hart 0)
        rd(2'd0, v); chk("R8 reset ctrl", v, 32'h0);
        rd(2'd3, v); chk("R6 reset status", v, 32'h03);
        chk("R3 reset halt_req", 32'(halt_req), 32'h0);
        chk("R4 reset resume_req", 32'(resume_req), 32'h0);

        for (int k = 0; k < 8; k++) begin
            hart_halted = VEC[k][15:12];
            wr(VEC[k][49:48], VEC[k][47:16]);
            rd(2'd3, v);
            chk($sformatf("R1/R2/R6 vector %0d status", k), v, 32'(VEC[k][11:4]));
            chk($sformatf("R1/R3 vector %0d halt_req", k), 32'(halt_req), 32'(VEC[k][3:0]));
        end

        // R5: halt and resume together
        hart_halted = 4'b1111;
        wr(2'd0, 32'hC000_0011);
        chk("R5 no resume pulse", 32'(resume_req), 32'h0);
        chk("R5 halt applied", 32'(halt_req), 32'h6);

        // R4: resume alone
        wr(2'd0, 32'h4000_0011);
        chk("R4 resume pulse", 32'(resume_req), 32'h2);
        chk("R3 halt cleared by write", 32'(halt_req), 32'h4);
        rd(2'd3, v); chk("R4 ack cleared", v, 32'h03);
        hart_halted = 4'b1101;
        @(negedge clk);
        chk("R4 pulse one cycle", 32'(resume_req), 32'h0);
        rd(2'd3, v); chk("R4 ack after running", v, 32'hCC);

        // R7: mask bits above hart count
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); chk("R7 mask width", v, 32'h0F);

        // R9: transfer clear ignores size and regno
        wr(2'd2, 32'h00F7_FFFF);
        chk("R9 start pulse", 32'(cmd_start), 32'h1);
        chk("R9 no xfer", {15'd0, cmd_xfer, cmd_regno}, 32'h0);
        rd(2'd2, v); chk("R9 no error", v, 32'h0);

        // R10: bad size, bad regno, good, bad type
        wr(2'd2, 32'h0078_1000);
        chk("R10 bad size no start", 32'(cmd_start), 32'h0);
        rd(2'd2, v); chk("R10 bad size err", v, 32'h2);
        wr(2'd2, 32'h0028_1020);
        rd(2'd2, v); chk("R10 bad regno err", v, 32'h2);
        wr(2'd2, 32'h002C_1005);
        chk("R10 good start", 32'(cmd_start), 32'h1);
        chk("R10 good fields", {14'd0, cmd_xfer, cmd_write, cmd_regno}, 32'h0003_1005);
        rd(2'd2, v); chk("R10 good err", v, 32'h0);
        wr(2'd2, 32'h0100_0000);
        rd(2'd2, v); chk("R10 bad type err", v, 32'h2);

        // R8: deactivate clears everything, later writes ignored
        wr(2'd0, 32'h8000_0000);
        chk("R8 halt_req cleared", 32'(halt_req), 32'h0);
        rd(2'd1, v); chk("R8 mask cleared", v, 32'h0);
        rd(2'd0, v); chk("R8 ctrl cleared", v, 32'h0);
        wr(2'd1, 32'h0000_000F);
        rd(2'd1, v); chk("R8 mask write ignored", v, 32'h0);
        wr(2'd2, 32'h0000_0000);
        chk("R8 cmd ignored", 32'(cmd_start), 32'h0);

        done = 1'b1;
        finish_run();
    end
endmodule